// File: doc/BRIEF.md
# Streaming Brightness and Contrast Adjuster

This block sits in a video path on the pixel clock and changes the brightness and contrast of 24-bit RGB pixels as they stream through. Each colour channel is scaled by an unsigned fixed-point gain and then shifted by a signed offset. The result is clamped to the 8-bit range. The horizontal sync, vertical sync and data-enable flags travel through a delay line exactly as long as the arithmetic, so the adjusted picture leaves the block aligned with its own timing. No line or frame is stored.

Sources can drive either sync with either polarity, depending on the video mode. Each sync therefore has an invert control, and the block emits both syncs active-high. Gain and offset come from static configuration inputs. The block copies them into working registers only at the rising edge of the normalised vertical sync, so a change made in the middle of a frame never splits a picture.

Top module: `pixel_adjust`

## Requirements
- R1: A pixel presented at the inputs appears, adjusted, at `out_rgb` exactly 3 clock edges later (input register, multiply, add-and-clamp).
- R2: `out_de`, `out_hs` and `out_vs` repeat the normalised input flags delayed by exactly the same 3 clocks as the pixel data.
- R3: When `hs_invert` is 1, `out_hs` is the complement of `in_hs`; when it is 0, `out_hs` follows `in_hs`. `vs_invert` acts the same way on the vertical sync.
- R4: While `out_de` is 0, `out_rgb` is 0 regardless of the pixel input.
- R5: Each channel is computed as floor(c * gain / 256) + offset. `gain_cfg` is unsigned 8.8 fixed point, so 0x0100 means 1.0. `offset_cfg` is a 9-bit two's-complement value.
- R6: A channel result above 255 is output as 255.
- R7: A channel result below 0 is output as 0.
- R8: Gain and offset are taken from `gain_cfg` and `offset_cfg` only at a rising edge of the normalised vertical sync. Changes made at other times have no effect on the output until the next such edge.
- R9: Red occupies bits 23:16, green bits 15:8 and blue bits 7:0. The three channels are computed independently with the same gain and offset.
- R10: After reset, all outputs are 0 and the working gain and offset are 1.0 and 0, so pixels pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_rgb | input | 24 | Input pixel, R in 23:16, G in 15:8, B in 7:0 |
| in_hs | input | 1 | Input horizontal sync, polarity per `hs_invert` |
| in_vs | input | 1 | Input vertical sync, polarity per `vs_invert` |
| in_de | input | 1 | Input active-video flag |
| hs_invert | input | 1 | 1: input horizontal sync is active-low |
| vs_invert | input | 1 | 1: input vertical sync is active-low |
| gain_cfg | input | 16 | Contrast gain, unsigned 8.8 |
| offset_cfg | input | 9 | Brightness offset, signed |
| out_rgb | output | 24 | Adjusted pixel |
| out_hs | output | 1 | Active-high horizontal sync, delayed |
| out_vs | output | 1 | Active-high vertical sync, delayed |
| out_de | output | 1 | Active-video flag, delayed |

## Verification
The hardest case to reach from the ports is a configuration change that must stay invisible. The new gain and offset only show up after a vertical-sync edge, so the bench first loads a known gain through a sync pulse. It then changes the configuration inputs during active video and checks that pixels still use the old values. Finally it pulses the vertical sync and confirms that the new values apply. The saturation corners get the same deliberate treatment: a large gain with a positive offset drives a result past 255, and a negative offset drives one below 0.

// File: rtl/pxadj_pkg.sv
package pxadj_pkg;
  localparam int CH_W    = 8;
  localparam int NUM_CH  = 3;
  localparam int PIX_W   = CH_W * NUM_CH;
  localparam int GAIN_W  = 16;
  localparam int FRAC_W  = 8;
  localparam int OFF_W   = 9;
  localparam int LATENCY = 3;
  localparam int PROD_W  = CH_W + GAIN_W;
  localparam int SUM_W   = PROD_W + 2;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } ctrl_t;
endpackage

// File: rtl/pxadj_sync_in.sv
module pxadj_sync_in
  import pxadj_pkg::*;
#(
  parameter int W = PIX_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_rgb,
  input  logic         in_hs,
  input  logic         in_vs,
  input  logic         in_de,
  input  logic         hs_invert,
  input  logic         vs_invert,
  output logic [W-1:0] s1_rgb,
  output ctrl_t        s1_ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rgb  <= '0;
      s1_ctrl <= '0;
    end else begin
      s1_rgb     <= in_rgb;
      s1_ctrl.hs <= in_hs ^ hs_invert;
      s1_ctrl.vs <= in_vs ^ vs_invert;
      s1_ctrl.de <= in_de;
    end
  end

  // R3: the registered sync is active-high after polarity correction
  a_r3_polarity: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (s1_ctrl.vs == ($past(in_vs) ^ $past(vs_invert))));
endmodule

// File: rtl/pxadj_param_latch.sv
module pxadj_param_latch
  import pxadj_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vs_norm,
  input  logic [GAIN_W-1:0] gain_cfg,
  input  logic [OFF_W-1:0]  offset_cfg,
  output logic [GAIN_W-1:0] gain_act,
  output logic [OFF_W-1:0]  offset_act
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC_W;

  logic vs_q;
  logic vs_rise;

  assign vs_rise = vs_norm & ~vs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q       <= 1'b0;
      gain_act   <= UNITY;
      offset_act <= '0;
    end else begin
      vs_q <= vs_norm;
      if (vs_rise) begin
        gain_act   <= gain_cfg;
        offset_act <= offset_cfg;
      end
    end
  end

  // R8: working parameters move only at a frame start
  a_r8_gain_hold: assert property (@(posedge clk) disable iff (rst)
    !vs_rise |=> $stable(gain_act));
  a_r8_offset_hold: assert property (@(posedge clk) disable iff (rst)
    !vs_rise |=> $stable(offset_act));
endmodule

// File: rtl/pxadj_channel.sv
module pxadj_channel
  import pxadj_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CH_W-1:0]   pix,
  input  logic [GAIN_W-1:0] gain,
  input  logic [OFF_W-1:0]  offset,
  input  logic              de_s2,
  output logic [CH_W-1:0]   result
);
  localparam logic [CH_W-1:0] MAXV = {CH_W{1'b1}};
  localparam logic signed [SUM_W-1:0] LIMIT = SUM_W'(1) << (CH_W + FRAC_W);

  logic [PROD_W-1:0]       prod_q;
  logic signed [OFF_W-1:0] off_q;
  logic signed [SUM_W-1:0] wide;
  logic [CH_W-1:0]         clamped;

  // stage 2: multiply, carry the offset alongside
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      off_q  <= '0;
    end else begin
      prod_q <= PROD_W'(pix) * PROD_W'(gain);
      off_q  <= offset;
    end
  end

  // offset is scaled into the fraction grid, so floor(p/256)+o is exact
  always_comb begin
    wide = $signed({2'b00, prod_q}) + ($signed(SUM_W'(off_q)) <<< FRAC_W);
    if (wide < 0)
      clamped = '0;
    else if (wide >= LIMIT)
      clamped = MAXV;
    else
      clamped = wide[CH_W+FRAC_W-1:FRAC_W];
  end

  // stage 3: add, clamp, blank
  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= de_s2 ? clamped : '0;
  end

  // R4: blanked stage never carries pixel data
  a_r4_blank: assert property (@(posedge clk) disable iff (rst)
    !de_s2 |=> (result == '0));
endmodule

// File: rtl/pxadj_ctrl_pipe.sv
module pxadj_ctrl_pipe
  import pxadj_pkg::*;
#(
  parameter int DEPTH = LATENCY - 1
) (
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t d,
  output ctrl_t mid,
  output ctrl_t q
);
  ctrl_t stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         stg[i] <= '0;
      else if (i == 0) stg[i] <= d;
      else             stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign mid = stg[DEPTH-2];
  assign q   = stg[DEPTH-1];
endmodule

// File: rtl/pixel_adjust.sv
module pixel_adjust
  import pxadj_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  in_rgb,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic              in_de,
  input  logic              hs_invert,
  input  logic              vs_invert,
  input  logic [GAIN_W-1:0] gain_cfg,
  input  logic [OFF_W-1:0]  offset_cfg,
  output logic [PIX_W-1:0]  out_rgb,
  output logic              out_hs,
  output logic              out_vs,
  output logic              out_de
);
  logic [PIX_W-1:0]  s1_rgb;
  ctrl_t             s1_ctrl, s2_ctrl, s3_ctrl;
  logic [GAIN_W-1:0] gain_act;
  logic [OFF_W-1:0]  offset_act;

  pxadj_sync_in #(.W(PIX_W)) u_in (
    .clk(clk), .rst(rst), .in_rgb(in_rgb), .in_hs(in_hs), .in_vs(in_vs),
    .in_de(in_de), .hs_invert(hs_invert), .vs_invert(vs_invert),
    .s1_rgb(s1_rgb), .s1_ctrl(s1_ctrl));

  pxadj_param_latch u_param (
    .clk(clk), .rst(rst), .vs_norm(s1_ctrl.vs), .gain_cfg(gain_cfg),
    .offset_cfg(offset_cfg), .gain_act(gain_act), .offset_act(offset_act));

  pxadj_ctrl_pipe #(.DEPTH(LATENCY-1)) u_ctrl (
    .clk(clk), .rst(rst), .d(s1_ctrl), .mid(s2_ctrl), .q(s3_ctrl));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pxadj_channel u_ch (
      .clk(clk), .rst(rst), .pix(s1_rgb[c*CH_W +: CH_W]), .gain(gain_act),
      .offset(offset_act), .de_s2(s2_ctrl.de),
      .result(out_rgb[c*CH_W +: CH_W]));
  end

  assign out_hs = s3_ctrl.hs;
  assign out_vs = s3_ctrl.vs;
  assign out_de = s3_ctrl.de;

  // cycles since reset, so delay checks never reach back into reset
  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (rst)                 warm <= '0;
    else if (warm < LATENCY) warm <= warm + 3'd1;
  end

  // R2: flags delayed by the full pipeline length
  a_r2_de_align: assert property (@(posedge clk) disable iff (rst)
    (warm == LATENCY) |-> (out_de == $past(in_de, 3)));
  a_r2_hs_align: assert property (@(posedge clk) disable iff (rst)
    (warm == LATENCY) |-> (out_hs == $past(in_hs ^ hs_invert, 3)));
  // R4: blanking at the port
  a_r4_port_blank: assert property (@(posedge clk) disable iff (rst)
    !out_de |-> (out_rgb == '0));
endmodule

// File: tb/pixel_adjust_test.sv
module pixel_adjust_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] in_rgb;
  logic        in_hs, in_vs, in_de, hs_invert, vs_invert;
  logic [15:0] gain_cfg;
  logic [8:0]  offset_cfg;
  logic [23:0] out_rgb;
  logic        out_hs, out_vs, out_de;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pixel_adjust uut (
    .clk(clk), .rst(rst), .in_rgb(in_rgb), .in_hs(in_hs), .in_vs(in_vs),
    .in_de(in_de), .hs_invert(hs_invert), .vs_invert(vs_invert),
    .gain_cfg(gain_cfg), .offset_cfg(offset_cfg), .out_rgb(out_rgb),
    .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(logic [7:0] c, logic [15:0] g, logic [8:0] o);
    int v;
    v = ((int'(c) * int'(g)) >>> 8) + int'($signed(o));
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v[7:0];
  endfunction

  // inputs back to an inactive line state
  task automatic idle();
    in_rgb = 24'h0;
    in_de  = 1'b0;
    in_hs  = hs_invert;
    in_vs  = vs_invert;
  endtask

  // present one pixel and return in the cycle its result is at the port
  task automatic pixel(logic [23:0] rgb);
    in_rgb = rgb; in_de = 1'b1;
    @(negedge clk); idle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic frame_start();
    in_vs = ~vs_invert;
    @(negedge clk); idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_pix(string req, logic [23:0] rgb, logic [15:0] g, logic [8:0] o);
    pixel(rgb);
    chk(req, out_rgb, {model(rgb[23:16], g, o), model(rgb[15:8], g, o), model(rgb[7:0], g, o)});
    chk(req, out_de, 1'b1);
  endtask

  task automatic t_reset();
    rst = 1'b1; hs_invert = 1'b0; vs_invert = 1'b0;
    gain_cfg = 16'h0300; offset_cfg = 9'd20; idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 rgb", out_rgb, 24'h0);
    chk("R10 flags", {out_hs, out_vs, out_de}, 3'b000);
    check_pix("R10 identity", 24'h12_80_FE, 16'h0100, 9'd0);
  endtask

  task automatic t_latency();
    in_rgb = 24'h55_66_77; in_de = 1'b1;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R1 not early", out_de, 1'b0);
    @(negedge clk);
    chk("R1 at three", out_rgb, 24'h55_66_77);
    @(negedge clk);
    chk("R1 single cycle", out_de, 1'b0);
  endtask

  task automatic t_arith();
    gain_cfg = 16'h0180; offset_cfg = 9'd10;
    frame_start();
    check_pix("R5 gain 1.5 offset 10", 24'h40_21_03, 16'h0180, 9'd10);
    check_pix("R9 channel independence", 24'h00_64_C8, 16'h0180, 9'd10);
  endtask

  task automatic t_saturate();
    gain_cfg = 16'h0200; offset_cfg = 9'd50;
    frame_start();
    check_pix("R6 clamp high", 24'hF0_64_60, 16'h0200, 9'd50);
    chk("R6 red 255", out_rgb[23:16], 8'hFF);
    gain_cfg = 16'h0100; offset_cfg = 9'h1C0; // -64
    frame_start();
    check_pix("R7 clamp low", 24'h10_40_90, 16'h0100, 9'h1C0);
    chk("R7 red 0", out_rgb[23:16], 8'h00);
  endtask

  task automatic t_blank();
    in_rgb = 24'hAB_CD_EF; in_de = 1'b0;
    @(negedge clk); idle();
    @(negedge clk); @(negedge clk);
    chk("R4 blank rgb", out_rgb, 24'h0);
    chk("R4 blank de", out_de, 1'b0);
  endtask

  task automatic t_midframe();
    gain_cfg = 16'h0200; offset_cfg = 9'd0;
    frame_start();
    check_pix("R8 loaded", 24'h32_32_32, 16'h0200, 9'd0);
    gain_cfg = 16'h0080; offset_cfg = 9'd7;
    check_pix("R8 held mid-frame", 24'h32_32_32, 16'h0200, 9'd0);
    frame_start();
    check_pix("R8 applied after sync", 24'h32_32_32, 16'h0080, 9'd7);
  endtask

  task automatic t_polarity();
    hs_invert = 1'b0; idle();
    in_hs = 1'b1; in_de = 1'b0;
    @(negedge clk); idle();
    @(negedge clk);
    chk("R2 hs not early", out_hs, 1'b0);
    @(negedge clk);
    chk("R2 hs aligned", out_hs, 1'b1);
    hs_invert = 1'b1; vs_invert = 1'b1; idle();
    repeat (4) @(negedge clk);
    chk("R3 inverted idle hs", out_hs, 1'b0);
    chk("R3 inverted idle vs", out_vs, 1'b0);
    in_hs = 1'b0; in_vs = 1'b0;
    @(negedge clk); idle();
    @(negedge clk); @(negedge clk);
    chk("R3 active-low hs", out_hs, 1'b1);
    chk("R2 R3 vs aligned", out_vs, 1'b1);
    hs_invert = 1'b0; vs_invert = 1'b0; idle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_arith();
    t_saturate();
    t_blank();
    t_midframe();
    t_polarity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule